// File: doc/BRIEF.md
# Output Window Power-Good Monitor

This block watches the regulated outputs of a multi-rail supply through their digitised samples and decides whether the system may be told that power is good. It receives one sample of the core output, three samples of linear rails together with each rail's nominal target, and a 5-bit voltage-identification code that selects the core reference. All values are unsigned ADC codes. The reference is computed from the code in centivolts and scaled by a parameter giving ADC codes per 10 mV (default 4, that is 2.5 mV per code).

The core output is judged against a window around the reference whose edges have hysteresis. A separate trip well above the window raises a core over-voltage flag. Each linear rail has its own up/down state with a rising and a falling threshold. The power-good output is high only when the core is inside its window and every linear rail is up. The all-ones identification code is a shutdown code and keeps power-good low. Every state bit and output changes only on a cycle with the sample strobe high. All thresholds are exact integer comparisons of `sample*100` against `reference*percent`.

Top module: `pgm_pwrgood_monitor`

## Requirements
- R1: With vid[4]=0 the core reference is (205 - 5*vid[3:0]) centivolts times CODES_PER_10MV, so 5'b01111 gives 1.30 V and 5'b00000 gives 2.05 V.
- R2: With vid[4]=1 the reference is 2.00 V for vid[3:0]=4'hF and otherwise (350 - 10*vid[3:0]) centivolts, so 5'b11110 gives 2.10 V and 5'b10000 gives 3.50 V.
- R3: A core sample with sample*100 > ref*110 puts the core out of window on its high side. The core stays there until a sample with sample*100 <= ref*108 arrives.
- R4: A core sample with sample*100 < ref*90 puts the core out of window on its low side. The core stays there until a sample with sample*100 >= ref*92 arrives.
- R5: core_ov_o is high after a strobed sample with sample*100 > ref*115 and low after any other strobed sample.
- R6: A linear rail that is down goes up on a sample with sample*100 > target*75.
- R7: A linear rail that is up goes down on a sample with sample*100 < target*68. rail_uv_o is high while any rail is down.
- R8: pwr_good_o is high only when the core is in window and all linear rails are up.
- R9: When the strobed code is 5'b11111, pwr_good_o is low whatever the samples are. The over-voltage trip still uses the 2.00 V reference.
- R10: Without sample_valid_i, the outputs and all internal states keep their values whatever the inputs do.
- R11: After synchronous reset, pwr_good_o=0, core_ov_o=0 and rail_uv_o=1. The core starts below window and all rails start down.
- R12: Outputs are registered. They reflect a strobed sample at the clock edge that captures the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_i | input | 5 | Core reference selection code |
| sample_valid_i | input | 1 | Strobe: samples and code are taken this cycle |
| core_code_i | input | W | Core output sample |
| rail_code_i | input | NRAIL*W | Linear rail samples, rail k at bits [k*W +: W] |
| rail_target_i | input | NRAIL*W | Nominal target per linear rail, same packing |
| pwr_good_o | output | 1 | Power good |
| core_ov_o | output | 1 | Core over-voltage |
| rail_uv_o | output | 1 | At least one linear rail is under-voltage |

## Verification
A wrong hysteresis state bit cannot be seen at the ports until a sample lands inside a hysteresis band. So the checks step samples one code at a time across each band and back. A faulty state then shows as a power-good value that differs on the very next strobe. Decode errors are caught by placing the core sample exactly on and one code above the upper trip for every non-shutdown code. Each of these shows within one strobe. Strobe gating is checked by moving samples with no strobe for several cycles and checking that no output moves.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

  localparam int VID_W = 5;

  // Core reference in centivolts for a 5-bit selection code.
  function automatic logic [8:0] vid_to_cv(input logic [VID_W-1:0] v);
    logic [8:0] low4;
    low4 = {5'd0, v[3:0]};
    if (!v[4]) begin
      vid_to_cv = 9'd205 - 9'd5 * low4;
    end else if (v[3:0] == 4'hF) begin
      vid_to_cv = 9'd200;
    end else begin
      vid_to_cv = 9'd350 - 9'd10 * low4;
    end
  endfunction

  localparam logic [VID_W-1:0] VID_SHUTDOWN = 5'b11111;

endpackage

// File: rtl/pgm_vid_ref.sv
module pgm_vid_ref
  import pgm_pkg::*;
#(
  parameter int W              = 12,
  parameter int CODES_PER_10MV = 4
) (
  input  logic [VID_W-1:0] vid,
  output logic [W-1:0]     ref_code
);
  localparam int PROD_W = 9 + 8;

  logic [8:0]        cv;
  logic [PROD_W-1:0] prod;

  always_comb begin
    cv       = vid_to_cv(vid);
    prod     = PROD_W'(cv) * PROD_W'(CODES_PER_10MV);
    ref_code = W'(prod);
  end

  // R1 / R2: decoded reference always within the 1.30 V .. 3.50 V span
  always_comb begin
    p_ref_span_r1: assert (cv >= 9'd130 && cv <= 9'd350);
  end

endmodule

// File: rtl/pgm_core_window.sv
module pgm_core_window #(
  parameter int W       = 12,
  parameter int UP_TRIP = 110,
  parameter int UP_CLR  = 108,
  parameter int LO_TRIP = 90,
  parameter int LO_CLR  = 92,
  parameter int OV_TRIP = 115
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd,
  input  logic [W-1:0] sample,
  input  logic [W-1:0] ref_code,
  output logic         good_n,
  output logic         ov_n,
  output logic         hi_q,
  output logic         lo_q,
  output logic         ov_q
);
  localparam int PW = W + 8;

  logic [PW-1:0] s100;
  logic [PW-1:0] r_up_trip, r_up_clr, r_lo_trip, r_lo_clr, r_ov;
  logic          hi_n, lo_n;

  always_comb begin
    s100      = PW'(sample)   * PW'(100);
    r_up_trip = PW'(ref_code) * PW'(UP_TRIP);
    r_up_clr  = PW'(ref_code) * PW'(UP_CLR);
    r_lo_trip = PW'(ref_code) * PW'(LO_TRIP);
    r_lo_clr  = PW'(ref_code) * PW'(LO_CLR);
    r_ov      = PW'(ref_code) * PW'(OV_TRIP);
    // the held state selects which edge applies
    hi_n   = hi_q ? (s100 > r_up_clr)  : (s100 > r_up_trip);
    lo_n   = lo_q ? (s100 < r_lo_clr)  : (s100 < r_lo_trip);
    ov_n   = s100 > r_ov;
    good_n = !hi_n && !lo_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= 1'b0;
      lo_q <= 1'b1;
      ov_q <= 1'b0;
    end else if (upd) begin
      hi_q <= hi_n;
      lo_q <= lo_n;
      ov_q <= ov_n;
    end
  end

  // R3 / R4: the core cannot be out of window on both sides at once
  p_side_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(hi_q && lo_q));

  // R5: an over-voltage sample always lies above the high window edge
  p_ov_above_win_r5: assert property (@(posedge clk) disable iff (rst)
    ov_q |-> hi_q);

  // R10: no state movement without a strobe
  p_core_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !upd |=> ($stable(hi_q) && $stable(lo_q) && $stable(ov_q)));

endmodule

// File: rtl/pgm_rail_uv.sv
module pgm_rail_uv #(
  parameter int W        = 12,
  parameter int RISE_PCT = 75,
  parameter int FALL_PCT = 68
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd,
  input  logic [W-1:0] sample,
  input  logic [W-1:0] target,
  output logic         up_n,
  output logic         up_q
);
  localparam int PW = W + 8;

  logic [PW-1:0] s100, t_rise, t_fall;

  always_comb begin
    s100   = PW'(sample) * PW'(100);
    t_rise = PW'(target) * PW'(RISE_PCT);
    t_fall = PW'(target) * PW'(FALL_PCT);
    up_n   = up_q ? (s100 >= t_fall) : (s100 > t_rise);
  end

  always_ff @(posedge clk) begin
    if (rst) up_q <= 1'b0;
    else if (upd) up_q <= up_n;
  end

  // R6: a rail only comes up on a strobe
  p_rail_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(up_q) |-> $past(upd));

  // R7: a rail only goes down on a strobe
  p_rail_fall_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(up_q) |-> $past(upd));

endmodule

// File: rtl/pgm_pwrgood_monitor.sv
module pgm_pwrgood_monitor
  import pgm_pkg::*;
#(
  parameter int W              = 12,
  parameter int NRAIL          = 3,
  parameter int CODES_PER_10MV = 4,
  parameter int RAIL_RISE_PCT  = 75,
  parameter int RAIL_FALL_PCT  = 68
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [4:0]         vid_i,
  input  logic               sample_valid_i,
  input  logic [W-1:0]       core_code_i,
  input  logic [NRAIL*W-1:0] rail_code_i,
  input  logic [NRAIL*W-1:0] rail_target_i,
  output logic               pwr_good_o,
  output logic               core_ov_o,
  output logic               rail_uv_o
);
  logic [W-1:0]     ref_code;
  logic             core_good_n, core_ov_n;
  logic             core_hi_q, core_lo_q, core_ov_q;
  logic [NRAIL-1:0] rail_up_n, rail_up_q;
  logic             shutdown;

  pgm_vid_ref #(.W(W), .CODES_PER_10MV(CODES_PER_10MV)) u_ref (
    .vid      (vid_i),
    .ref_code (ref_code)
  );

  pgm_core_window #(.W(W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .upd      (sample_valid_i),
    .sample   (core_code_i),
    .ref_code (ref_code),
    .good_n   (core_good_n),
    .ov_n     (core_ov_n),
    .hi_q     (core_hi_q),
    .lo_q     (core_lo_q),
    .ov_q     (core_ov_q)
  );

  for (genvar k = 0; k < NRAIL; k++) begin : g_rail
    pgm_rail_uv #(.W(W), .RISE_PCT(RAIL_RISE_PCT), .FALL_PCT(RAIL_FALL_PCT)) u_rail (
      .clk    (clk),
      .rst    (rst),
      .upd    (sample_valid_i),
      .sample (rail_code_i[k*W +: W]),
      .target (rail_target_i[k*W +: W]),
      .up_n   (rail_up_n[k]),
      .up_q   (rail_up_q[k])
    );
  end

  assign shutdown = (vid_i == VID_SHUTDOWN);

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_good_o <= 1'b0;
      core_ov_o  <= 1'b0;
      rail_uv_o  <= 1'b1;
    end else if (sample_valid_i) begin
      pwr_good_o <= core_good_n && (&rail_up_n) && !shutdown;
      core_ov_o  <= core_ov_n;
      rail_uv_o  <= !(&rail_up_n);
    end
  end

  // R8: power good implies every rail is up and the core is in window
  p_pg_rails_r8: assert property (@(posedge clk) disable iff (rst)
    pwr_good_o |-> (!rail_uv_o && (&rail_up_q) && !core_hi_q && !core_lo_q));

  // R9: shutdown code keeps power good low
  p_shutdown_r9: assert property (@(posedge clk) disable iff (rst)
    (sample_valid_i && vid_i == VID_SHUTDOWN) |=> !pwr_good_o);

  // R10: outputs hold without a strobe
  p_out_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !sample_valid_i |=> ($stable(pwr_good_o) && $stable(core_ov_o) && $stable(rail_uv_o)));

  // R5: registered flag agrees with the core comparator state
  p_ov_match_r5: assert property (@(posedge clk) disable iff (rst)
    core_ov_o == core_ov_q);

endmodule

// File: tb/pgm_pwrgood_monitor_test.sv
module pgm_pwrgood_monitor_test;
  localparam int W = 12;
  localparam int NRAIL = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] vid = 5'd0;
  logic valid = 1'b0;
  logic [W-1:0] core = '0;
  logic [NRAIL*W-1:0] rails = '0;
  logic [NRAIL*W-1:0] targets;
  logic pg, ov, uv;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pgm_pwrgood_monitor #(.W(W), .NRAIL(NRAIL)) uut (
    .clk(clk), .rst(rst), .vid_i(vid), .sample_valid_i(valid),
    .core_code_i(core), .rail_code_i(rails), .rail_target_i(targets),
    .pwr_good_o(pg), .core_ov_o(ov), .rail_uv_o(uv)
  );

  localparam int T0 = 600, T1 = 720, T2 = 1320;
  assign targets = {12'(T2), 12'(T1), 12'(T0)};

  function automatic int ref_of(int v);
    if (v < 16) return 4 * (130 + 5 * (15 - v));
    if (v == 31) return 800;
    return 4 * (210 + 10 * (30 - v));
  endfunction

  task automatic check(string req, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic apply(int v, int c, int r0, int r1, int r2);
    @(negedge clk);
    vid = 5'(v); core = 12'(c);
    rails = {12'(r2), 12'(r1), 12'(r0)};
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R11", pg, 1'b0, "pg after reset");
    check("R11", ov, 1'b0, "ov after reset");
    check("R11", uv, 1'b1, "uv after reset");
  endtask

  // R1, R2: exact upper-trip boundary for every non-shutdown code
  task automatic t_decode();
    for (int v = 0; v < 31; v++) begin
      int r = ref_of(v);
      int edge_ok = (r * 110) / 100;
      apply(v, edge_ok, T0, T1, T2);
      check(v < 16 ? "R1" : "R2", pg, 1'b1, $sformatf("pg on edge vid=%0d", v));
      apply(v, edge_ok + 1, T0, T1, T2);
      check(v < 16 ? "R1" : "R2", pg, 1'b0, $sformatf("pg above edge vid=%0d", v));
      apply(v, r, T0, T1, T2);
    end
  endtask

  task automatic t_upper_hyst();
    apply(15, 520, T0, T1, T2);
    check("R3", pg, 1'b1, "pg at reference");
    apply(15, 573, T0, T1, T2);
    check("R3", pg, 1'b0, "pg above 110%");
    apply(15, 565, T0, T1, T2);
    check("R3", pg, 1'b0, "pg inside band");
    apply(15, 562, T0, T1, T2);
    check("R3", pg, 1'b0, "pg just above 108%");
    apply(15, 561, T0, T1, T2);
    check("R3", pg, 1'b1, "pg at/below 108%");
  endtask

  task automatic t_lower_hyst();
    apply(15, 468, T0, T1, T2);
    check("R4", pg, 1'b1, "pg at 90% edge");
    apply(15, 467, T0, T1, T2);
    check("R4", pg, 1'b0, "pg below 90%");
    apply(15, 470, T0, T1, T2);
    check("R4", pg, 1'b0, "pg inside band");
    apply(15, 478, T0, T1, T2);
    check("R4", pg, 1'b0, "pg just below 92%");
    apply(15, 479, T0, T1, T2);
    check("R4", pg, 1'b1, "pg at 92%");
  endtask

  task automatic t_ov();
    apply(16, 1610, T0, T1, T2);
    check("R5", ov, 1'b0, "ov at 115%");
    apply(16, 1611, T0, T1, T2);
    check("R5", ov, 1'b1, "ov above 115%");
    check("R8", pg, 1'b0, "pg during ov");
    apply(16, 1400, T0, T1, T2);
    check("R5", ov, 1'b0, "ov cleared");
    check("R5", pg, 1'b1, "pg after ov cleared");
  endtask

  task automatic t_linear();
    apply(15, 520, 407, T1, T2);
    check("R7", uv, 1'b1, "uv rail0 below 68%");
    check("R8", pg, 1'b0, "pg with rail0 down");
    apply(15, 520, 450, T1, T2);
    check("R6", uv, 1'b1, "uv rail0 at 75%");
    apply(15, 520, 451, T1, T2);
    check("R6", uv, 1'b0, "uv rail0 above 75%");
    check("R8", pg, 1'b1, "pg all rails up");
    apply(15, 520, 408, T1, T2);
    check("R7", uv, 1'b0, "uv rail0 at 68%");
    apply(15, 520, T0, T1, 897);
    check("R7", uv, 1'b1, "uv rail2 below 68%");
    apply(15, 520, T0, T1, 990);
    check("R6", uv, 1'b1, "uv rail2 at 75%");
    apply(15, 520, T0, T1, 991);
    check("R6", uv, 1'b0, "uv rail2 above 75%");
    apply(15, 900, T0, T1, T2);
    check("R8", pg, 1'b0, "pg core high rails up");
    check("R8", uv, 1'b0, "uv core high rails up");
    apply(15, 520, T0, T1, T2);
  endtask

  task automatic t_shutdown();
    apply(31, 800, T0, T1, T2);
    check("R9", pg, 1'b0, "pg shutdown code");
    check("R9", uv, 1'b0, "uv shutdown code");
    apply(31, 920, T0, T1, T2);
    check("R9", ov, 1'b0, "ov at 115% of 2.00V");
    apply(31, 921, T0, T1, T2);
    check("R9", ov, 1'b1, "ov above 115% of 2.00V");
    apply(30, 840, T0, T1, T2);
    check("R9", pg, 1'b1, "pg after leaving shutdown");
  endtask

  task automatic t_strobe();
    @(negedge clk);
    core = 12'd2000; rails = '0; vid = 5'd31;
    repeat (4) @(negedge clk);
    check("R10", pg, 1'b1, "pg without strobe");
    check("R10", uv, 1'b0, "uv without strobe");
    check("R10", ov, 1'b0, "ov without strobe");
    apply(30, 840, T0, T1, T2);
    check("R12", pg, 1'b1, "pg one strobe later");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_decode();
    t_upper_hyst();
    t_lower_hyst();
    t_ov();
    t_linear();
    t_shutdown();
    t_strobe();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule